// File: doc/BRIEF.md
# Program Counter Breakpoint Unit

This block watches a program counter and raises an interrupt when the counter reaches a programmed address. It holds two breakpoint addresses. The host-facing address can be written and read by an external host. The local CPU can read that address but cannot change it. The second address is loaded by the local CPU. A match against either address raises the same interrupt.

A stored address of zero disarms that breakpoint. Once the interrupt is raised, it stays high until the host writes zero to its address. That write both disarms the host breakpoint and clears the pending interrupt. The program counter is compared only on cycles where its valid strobe is high. All outputs come straight from registers.

Top module: `bp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both breakpoint addresses become zero and `bp_irq` becomes low.
- R2: A host write (`host_wr_en` high) stores `host_wr_data` at the clock edge. From the next cycle, both `host_rd_data` and `cpu_rd_host` show the stored value.
- R3: A CPU write with `cpu_wr_sel` = 0 targets the host-facing address and is ignored. That address and its readbacks stay unchanged.
- R4: A CPU write with `cpu_wr_sel` = 1 stores `cpu_wr_data` in the local address. From the next cycle, `cpu_rd_local` shows the stored value.
- R5: When `pc_valid` is high and `pc` equals the nonzero host-facing address, `bp_irq` is high from the following cycle.
- R6: When `pc_valid` is high and `pc` equals the nonzero local address, `bp_irq` is high from the following cycle.
- R7: A `pc` that equals a stored address while `pc_valid` is low does not raise `bp_irq`.
- R8: An address holding zero never matches, even when `pc` is zero.
- R9: `bp_irq` is sticky. It stays high while `pc` moves away, through CPU writes, and through host writes of nonzero values.
- R10: A host write of zero makes `bp_irq` low from the next cycle.
- R11: If a host write of zero and a match occur in the same cycle, the clear wins and `bp_irq` is low in the next cycle.
- R12: The comparison uses the address held at the start of the cycle. A write in the same cycle affects matching only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | 1 | Program counter strobe; `pc` is compared only when this is high |
| pc | input | PC_W | Program counter value |
| host_wr_en | input | 1 | Host write strobe for the host-facing address |
| host_wr_data | input | PC_W | Host write value; zero also clears the interrupt |
| host_rd_data | output | PC_W | Host readback of the host-facing address |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_sel | input | 1 | CPU write target: 0 = host-facing address (ignored), 1 = local address |
| cpu_wr_data | input | PC_W | CPU write value |
| cpu_rd_host | output | PC_W | CPU read-only view of the host-facing address |
| cpu_rd_local | output | PC_W | CPU readback of the local address |
| bp_irq | output | 1 | Sticky breakpoint interrupt |

## Verification
Every result is due exactly one clock after its stimulus:
- a write appears on its readback ports in the next cycle;
- a match, or a clearing write, shows on `bp_irq` in the next cycle.

The bench applies inputs on the falling edge and advances its behavioural model at the rising edge. It compares all four outputs at the following falling edge, which is exactly one register stage after the stimulus.

The directed steps place the same-cycle cases in single cycles: a clear that coincides with a match, and a write to the address that `pc` hits in that same cycle. A randomized run then aims `pc` at the stored addresses and at zero.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned BP_PC_W = 16;
  localparam int unsigned BP_NUM  = 2;

  typedef enum logic {
    SEL_HOST  = 1'b0,
    SEL_LOCAL = 1'b1
  } bp_sel_e;
endpackage

// File: rtl/bp_reg.sv
module bp_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/bp_cmp.sv
module bp_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         pc_valid,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] bp_addr,
  output logic         hit
);
  logic armed;
  assign armed = |bp_addr;
  assign hit   = pc_valid && armed && (pc == bp_addr);
endmodule

// File: rtl/bp_flag.sv
module bp_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr && set) |=> !flag);
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r5_set: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> flag);
endmodule

// File: rtl/bp_unit.sv
module bp_unit #(
  parameter int unsigned PC_W = bp_pkg::BP_PC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_valid,
  input  logic [PC_W-1:0] pc,
  input  logic            host_wr_en,
  input  logic [PC_W-1:0] host_wr_data,
  output logic [PC_W-1:0] host_rd_data,
  input  logic            cpu_wr_en,
  input  logic            cpu_wr_sel,
  input  logic [PC_W-1:0] cpu_wr_data,
  output logic [PC_W-1:0] cpu_rd_host,
  output logic [PC_W-1:0] cpu_rd_local,
  output logic            bp_irq
);
  import bp_pkg::*;
  localparam int unsigned NUM = BP_NUM;

  logic [PC_W-1:0] host_q, local_q;
  logic [PC_W-1:0] addr_arr [NUM];
  logic [NUM-1:0]  hits;
  logic            local_we, host_clr;

  // Only a write aimed at the local address is accepted from the CPU (R4);
  // the host-facing address has no CPU write path (R3).
  assign local_we = cpu_wr_en && (bp_sel_e'(cpu_wr_sel) == SEL_LOCAL);
  assign host_clr = host_wr_en && (host_wr_data == '0);

  bp_reg #(.W(PC_W)) u_host_reg (
    .clk(clk), .rst(rst), .we(host_wr_en), .d(host_wr_data), .q(host_q)
  );
  bp_reg #(.W(PC_W)) u_local_reg (
    .clk(clk), .rst(rst), .we(local_we), .d(cpu_wr_data), .q(local_q)
  );

  assign addr_arr[0] = host_q;
  assign addr_arr[1] = local_q;

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    bp_cmp #(.W(PC_W)) u_cmp (
      .pc_valid(pc_valid), .pc(pc), .bp_addr(addr_arr[i]), .hit(hits[i])
    );
  end

  bp_flag u_flag (
    .clk(clk), .rst(rst), .set(|hits), .clr(host_clr), .flag(bp_irq)
  );

  assign host_rd_data = host_q;
  assign cpu_rd_host  = host_q;
  assign cpu_rd_local = local_q;

  a_r2_host_write: assert property (@(posedge clk) disable iff (rst)
    host_wr_en |=> (cpu_rd_host == $past(host_wr_data)));
  a_r3_cpu_no_host_write: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_en && !cpu_wr_sel && !host_wr_en) |=> $stable(host_rd_data));
  a_r7_needs_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(bp_irq) |-> $past(pc_valid));
  a_r8_zero_pc_no_hit: assert property (@(posedge clk) disable iff (rst)
    (pc_valid && (pc == '0) && !bp_irq) |=> !bp_irq);
endmodule

// File: tb/tb_bp_unit.sv
module tb_bp_unit;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_valid = 1'b0;
  logic [W-1:0] pc = '0;
  logic host_wr_en = 1'b0;
  logic [W-1:0] host_wr_data = '0;
  logic cpu_wr_en = 1'b0;
  logic cpu_wr_sel = 1'b0;
  logic [W-1:0] cpu_wr_data = '0;
  logic [W-1:0] host_rd_data, cpu_rd_host, cpu_rd_local;
  logic bp_irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_host = 0, m_local = 0, m_irq = 0;

  always #5 clk = ~clk;

  bp_unit #(.PC_W(W)) dut (
    .clk(clk), .rst(rst), .pc_valid(pc_valid), .pc(pc),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_sel(cpu_wr_sel), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_host(cpu_rd_host), .cpu_rd_local(cpu_rd_local), .bp_irq(bp_irq)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit hit, clr;
    hit = pc_valid && ((m_host != 0 && int'(pc) == m_host) ||
                       (m_local != 0 && int'(pc) == m_local));
    clr = host_wr_en && (host_wr_data == 0);
    if (clr)      m_irq = 0;
    else if (hit) m_irq = 1;
    if (host_wr_en) m_host = int'(host_wr_data);
    if (cpu_wr_en && cpu_wr_sel) m_local = int'(cpu_wr_data);
  endtask

  task automatic step(bit v, int p, bit hwe, int hwd, bit cwe, bit csel, int cwd, string tag);
    pc_valid = v; pc = W'(p);
    host_wr_en = hwe; host_wr_data = W'(hwd);
    cpu_wr_en = cwe; cpu_wr_sel = csel; cpu_wr_data = W'(cwd);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, int'(bp_irq), m_irq);
    check("R2 host readback", int'(host_rd_data), m_host);
    check("R2 cpu view of host address", int'(cpu_rd_host), m_host);
    check("R4 local readback", int'(cpu_rd_local), m_local);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq at reset", int'(bp_irq), 0);
    check("R1 host address at reset", int'(host_rd_data), 0);
    check("R1 local address at reset", int'(cpu_rd_local), 0);
    rst = 1'b0;

    step(0, 0, 1, 'h1234, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, 'hBEEF, "R3");
    check("R3 cpu write ignored", int'(cpu_rd_host), 'h1234);
    step(0, 0, 0, 0, 1, 1, 'h0042, "R4");
    check("R4 local stored", int'(cpu_rd_local), 'h0042);
    step(0, 'h1234, 0, 0, 0, 0, 0, "R7");
    check("R7 no match without valid", int'(bp_irq), 0);
    step(1, 'h1234, 0, 0, 0, 0, 0, "R5");
    check("R5 host match", int'(bp_irq), 1);
    step(1, 'h5555, 0, 0, 1, 1, 'h0042, "R9");
    step(1, 'h6666, 1, 'h0100, 0, 0, 0, "R9");
    check("R9 sticky", int'(bp_irq), 1);
    step(0, 0, 1, 0, 0, 0, 0, "R10");
    check("R10 clear", int'(bp_irq), 0);
    step(1, 'h0042, 0, 0, 0, 0, 0, "R6");
    check("R6 local match", int'(bp_irq), 1);
    step(0, 0, 1, 0, 1, 1, 0, "R10");
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    check("R8 zero never matches", int'(bp_irq), 0);
    step(0, 0, 1, 'h2222, 0, 0, 0, "R2");
    step(1, 'h2222, 1, 0, 0, 0, 0, "R11");
    check("R11 clear wins", int'(bp_irq), 0);
    step(1, 'h3333, 1, 'h3333, 0, 0, 0, "R12");
    check("R12 old address used", int'(bp_irq), 0);
    step(1, 'h3333, 0, 0, 0, 0, 0, "R12");
    check("R12 new address matches", int'(bp_irq), 1);
    step(0, 0, 1, 0, 0, 0, 0, "R10");

    for (int i = 0; i < 400; i++) begin
      int sel, p;
      sel = int'($urandom_range(0, 3));
      p = (sel == 0) ? m_host : (sel == 1) ? m_local : (sel == 2) ? 0 : int'($urandom_range(0, 15));
      step(($urandom_range(0, 3) != 0), p,
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 15)),
           ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           "R6");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule